// File: doc/BRIEF.md
# SD SPI-Mode Command Transaction Engine

This block runs a single command exchange with a memory card that is wired in SPI mode. A host pulses `start` with a 6-bit command number and a 32-bit argument. The engine then pulls chip select low and pushes the six-byte command frame through an external byte shifter. After the frame it sends filler bytes of 0xFF and watches each byte that comes back until the card answers. It hands the one-byte status back to the host and reports `done`.

Two commands return four more bytes after the status: the interface-condition query (command 8) and the operating-condition read (command 58). For these the engine collects the four bytes into a 32-bit word. If the card stays silent for a bounded number of polled bytes, the engine gives up and flags a timeout. In normal mode it raises chip select afterwards and clocks one more filler byte so the card can release its output. In keep-selected mode it leaves the card selected after a good answer, so that a data-block read can follow straight away.

The bit shifter and CRC computation sit outside this block. The CRC byte of the frame comes from a fixed choice made per command.

Top module: `sdspi_cmd_seq`

## Requirements
- R1: The first frame byte is 0x40 OR the 6-bit command number. Bytes two to five carry the argument, most significant byte first. Chip select is low for all six frame bytes.
- R2: The sixth frame byte is 0x87 when the command number is 8 and 0x95 for every other command. For command 8 the argument bytes are always 0x00, 0x00, 0x01, 0xAA, whatever `cmd_arg` holds.
- R3: After the frame the engine sends 0xFF and discards every received byte with bit 7 set. The first received byte with bit 7 clear appears unchanged on `r1` (bit 0 idle, bit 1 erase reset, bit 2 illegal command, bit 3 command CRC error, bit 4 erase sequence error, bit 5 address error, bit 6 parameter error).
- R4: If POLL_LIMIT (default 5000) polled bytes all have bit 7 set, the engine sends no further poll byte and sets `timeout` to 1 and `r1` to 0xFF.
- R5: For commands 8 and 58, a valid status is followed by four more 0xFF transfers. `ext` then holds the four received bytes, the first received in bits 31:24. For other commands no extra byte is sent and `ext` reads 0.
- R6: In normal mode, after the status (and extra bytes), or after a timeout, chip select goes high. Exactly one 0xFF byte is then sent with chip select high, and `done` follows.
- R7: In keep-selected mode (`keep_sel` sampled at start), a valid status ends the transaction with no trailing byte, and chip select stays low after `done`. A timeout in this mode behaves as in R6.
- R8: A `start` pulse while `busy` is high is ignored. The byte stream, results and the single `done` of the running transaction are unchanged.
- R9: After reset, `cs_n` is 1 and `busy`, `done`, `xfer_req` and `timeout` are 0, with `r1` and `ext` at 0.
- R10: `xfer_req` stays high with `xfer_tx` stable until `xfer_ack`. `done` is a one-cycle pulse during which `busy` is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (taken only while idle) |
| cmd_idx | input | 6 | Command number |
| cmd_arg | input | 32 | Command argument |
| keep_sel | input | 1 | Keep chip select low after a valid status |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| r1 | output | 8 | Status byte received (0xFF on timeout) |
| ext | output | 32 | Four trailing bytes, first received most significant |
| timeout | output | 1 | No status within the poll limit |
| cs_n | output | 1 | Card chip select, active low |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Shifter finished the byte, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received during the transfer |

## Verification
A wrong frame index or a wrong CRC choice shows up as a bad byte on `xfer_tx` within six transfers of `start`. A poll counter that is off shows up as a poll count other than POLL_LIMIT before `timeout`. A bad response or extra-byte state shows as too many or too few 0xFF transfers. It can also show as a misplaced byte in `ext`, or as `done` arriving before or after the trailing byte. Chip-select errors are visible on the byte where `cs_n` has the wrong level, and after `done` in keep-selected mode. A start that is not ignored corrupts the frame bytes of the transaction in flight.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
  localparam int          FRAME_LEN    = 6;
  localparam int          EXT_LEN      = 4;
  localparam logic [5:0]  CMD_IF_COND  = 6'd8;
  localparam logic [5:0]  CMD_RD_OCR   = 6'd58;
  localparam logic [7:0]  CRC_GENERIC  = 8'h95;
  localparam logic [7:0]  CRC_IF_COND  = 8'h87;
  localparam logic [31:0] ARG_IF_COND  = 32'h0000_01AA;
  localparam logic [7:0]  FILL_BYTE    = 8'hFF;
  localparam logic [1:0]  FRAME_PREFIX = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_POLL,
    ST_EXTRA,
    ST_TAIL
  } seq_state_t;

  function automatic logic wants_ext(input logic [5:0] c);
    return (c == CMD_IF_COND) || (c == CMD_RD_OCR);
  endfunction
endpackage

// File: rtl/sdspi_frame_gen.sv
module sdspi_frame_gen
  import sdspi_pkg::*;
#(
  parameter int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic [5:0]       cmd,
  input  logic [31:0]      arg,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);
  localparam int ARG_BYTES = 4;

  logic        is_cond;
  logic [31:0] eff_arg;
  logic [7:0]  crc_b;
  logic [7:0]  arg_b [ARG_BYTES];

  assign is_cond = (cmd == CMD_IF_COND);
  assign eff_arg = is_cond ? ARG_IF_COND : arg;
  assign crc_b   = is_cond ? CRC_IF_COND : CRC_GENERIC;

  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_argb
    assign arg_b[g] = eff_arg[31-8*g -: 8];
  end

  always_comb begin
    byte_o = FILL_BYTE;
    if (idx == '0) begin
      byte_o = {FRAME_PREFIX, cmd};
    end else if (idx == IDX_W'(FRAME_LEN-1)) begin
      byte_o = crc_b;
    end else if (idx <= IDX_W'(ARG_BYTES)) begin
      byte_o = arg_b[2'(idx - IDX_W'(1))];
    end
  end
endmodule

// File: rtl/sdspi_byte_port.sv
module sdspi_byte_port
  import sdspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [7:0] tx_in,
  output logic       xfer_req,
  output logic [7:0] xfer_tx,
  input  logic       xfer_ack,
  input  logic [7:0] xfer_rx,
  output logic       fin,
  output logic [7:0] rx_byte
);
  assign fin     = xfer_req & xfer_ack;
  assign rx_byte = xfer_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_req <= 1'b0;
      xfer_tx  <= FILL_BYTE;
    end else if (issue) begin
      xfer_req <= 1'b1;
      xfer_tx  <= tx_in;
    end else if (fin) begin
      xfer_req <= 1'b0;
    end
  end

  // R10: request and byte held until the shifter acknowledges
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx));
  // R10: a new byte is never launched over a pending one
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    issue |-> !xfer_req);
endmodule

// File: rtl/sdspi_poll_ctr.sv
module sdspi_poll_ctr #(
  parameter int LIMIT = 5000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic last
);
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + CW'(1);
  end

  // R4: the number of polled bytes never runs past the limit
  a_r4_poll_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/sdspi_cmd_seq.sv
module sdspi_cmd_seq
  import sdspi_pkg::*;
#(
  parameter int POLL_LIMIT = 5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        keep_sel,
  output logic        busy,
  output logic        done,
  output logic [7:0]  r1,
  output logic [31:0] ext,
  output logic        timeout,
  output logic        cs_n,
  output logic        xfer_req,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_ack,
  input  logic [7:0]  xfer_rx
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam int XW    = $clog2(EXT_LEN);

  seq_state_t       st;
  logic [5:0]       cmd_q;
  logic [31:0]      arg_q;
  logic             keep_q;
  logic             ext_q;
  logic [IDX_W-1:0] fidx;
  logic [XW-1:0]    xcnt;
  logic             launch;
  logic [7:0]       frame_b;
  logic [7:0]       tx_next;
  logic             fin;
  logic [7:0]       rx_b;
  logic             poll_last;
  logic             accept;

  assign accept  = start && (st == ST_IDLE);
  assign tx_next = (st == ST_FRAME) ? frame_b : FILL_BYTE;

  sdspi_frame_gen #(.IDX_W(IDX_W)) u_frame (
    .cmd    (cmd_q),
    .arg    (arg_q),
    .idx    (fidx),
    .byte_o (frame_b)
  );

  sdspi_byte_port u_port (
    .clk      (clk),
    .rst      (rst),
    .issue    (launch),
    .tx_in    (tx_next),
    .xfer_req (xfer_req),
    .xfer_tx  (xfer_tx),
    .xfer_ack (xfer_ack),
    .xfer_rx  (xfer_rx),
    .fin      (fin),
    .rx_byte  (rx_b)
  );

  sdspi_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .step (fin && (st == ST_POLL)),
    .last (poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cmd_q   <= '0;
      arg_q   <= '0;
      keep_q  <= 1'b0;
      ext_q   <= 1'b0;
      fidx    <= '0;
      xcnt    <= '0;
      launch  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      r1      <= '0;
      ext     <= '0;
      timeout <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      done   <= 1'b0;
      launch <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            cmd_q   <= cmd_idx;
            arg_q   <= cmd_arg;
            keep_q  <= keep_sel;
            ext_q   <= wants_ext(cmd_idx);
            fidx    <= '0;
            xcnt    <= '0;
            ext     <= '0;
            timeout <= 1'b0;
            cs_n    <= 1'b0;
            busy    <= 1'b1;
            launch  <= 1'b1;
            st      <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (fin) begin
            launch <= 1'b1;
            if (fidx == IDX_W'(FRAME_LEN - 1)) st <= ST_POLL;
            else fidx <= fidx + IDX_W'(1);
          end
        end
        ST_POLL: begin
          if (fin) begin
            if (!rx_b[7]) begin
              r1 <= rx_b;
              if (ext_q) begin
                st     <= ST_EXTRA;
                launch <= 1'b1;
              end else if (keep_q) begin
                st   <= ST_IDLE;
                busy <= 1'b0;
                done <= 1'b1;
              end else begin
                cs_n   <= 1'b1;
                st     <= ST_TAIL;
                launch <= 1'b1;
              end
            end else if (poll_last) begin
              timeout <= 1'b1;
              r1      <= 8'hFF;
              cs_n    <= 1'b1;
              st      <= ST_TAIL;
              launch  <= 1'b1;
            end else begin
              launch <= 1'b1;
            end
          end
        end
        ST_EXTRA: begin
          if (fin) begin
            ext <= {ext[23:0], rx_b};
            if (xcnt == XW'(EXT_LEN - 1)) begin
              if (keep_q) begin
                st   <= ST_IDLE;
                busy <= 1'b0;
                done <= 1'b1;
              end else begin
                cs_n   <= 1'b1;
                st     <= ST_TAIL;
                launch <= 1'b1;
              end
            end else begin
              xcnt   <= xcnt + XW'(1);
              launch <= 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (fin) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse, seen with busy already low
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: no byte request outside a transaction
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !xfer_req);
  // R6: the trailing byte goes out with the card deselected
  a_r6_tail_desel: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TAIL) && xfer_req |-> cs_n);
  // R6: normal completion or timeout leaves the card released
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    done && (!keep_q || timeout) |-> cs_n);
  // R7: keep-selected completion leaves the card selected
  a_r7_hold_sel: assert property (@(posedge clk) disable iff (rst)
    done && keep_q && !timeout |-> !cs_n);
  // R1: frame and poll bytes are always sent with the card selected
  a_r1_frame_sel: assert property (@(posedge clk) disable iff (rst)
    xfer_req && (st == ST_FRAME || st == ST_POLL) |-> !cs_n);
  // R8: a start during a transaction leaves the latched command alone
  a_r8_ignore_start: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(cmd_q) && $stable(arg_q));
  // R4: a timeout always reports the all-ones status
  a_r4_timeout_r1: assert property (@(posedge clk) disable iff (rst)
    done && timeout |-> r1 == 8'hFF);
endmodule

// File: tb/sdspi_cmd_seq_bench.sv
module sdspi_cmd_seq_bench;
  localparam int LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        keep_sel = 1'b0;
  logic        busy, done, timeout, cs_n, xfer_req;
  logic [7:0]  r1, xfer_tx;
  logic [31:0] ext;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'hFF;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;

  logic [7:0] reply_q [$];
  logic [7:0] tx_log  [$];
  logic       cs_log  [$];

  always #2 clk = ~clk;

  sdspi_cmd_seq #(.POLL_LIMIT(LIMIT)) u_sdspi_cmd_seq (
    .clk(clk), .rst(rst), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .keep_sel(keep_sel), .busy(busy), .done(done), .r1(r1), .ext(ext),
    .timeout(timeout), .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // card model: answers each request after a varying delay
  initial begin
    int wait_c = 0;
    int nbytes = 0;
    forever begin
      @(negedge clk);
      if (xfer_ack) begin
        xfer_ack = 1'b0;
      end else if (xfer_req) begin
        if (wait_c < (nbytes % 3)) begin
          wait_c++;
        end else begin
          wait_c = 0;
          nbytes++;
          tx_log.push_back(xfer_tx);
          cs_log.push_back(cs_n);
          xfer_rx  = (reply_q.size() > 0) ? reply_q.pop_front() : 8'hFF;
          xfer_ack = 1'b1;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
    $finish;
  end

  // nbusy < 0 means the card never answers
  task automatic run(input logic [5:0] c, input logic [31:0] a, input bit keep,
                     input int nbusy, input logic [7:0] rv,
                     input logic [31:0] xv, input bit hijack, input string tag);
    logic [7:0] exp_b [$];
    logic       exp_c [$];
    bit         has_x, tmo;
    logic [31:0] ea;
    int cyc;
    has_x = (c == 6'd8) || (c == 6'd58);
    tmo   = (nbusy < 0);
    ea    = (c == 6'd8) ? 32'h0000_01AA : a;
    reply_q.delete(); tx_log.delete(); cs_log.delete();
    for (int i = 0; i < 6; i++) reply_q.push_back(8'hFF);
    if (!tmo) begin
      for (int i = 0; i < nbusy; i++) reply_q.push_back(8'h80 | 8'(i * 37));
      reply_q.push_back(rv);
      if (has_x) for (int i = 0; i < 4; i++) reply_q.push_back(xv[31-8*i -: 8]);
    end
    // reference byte stream
    exp_b.push_back(8'h40 | {2'b00, c});
    for (int i = 0; i < 4; i++) exp_b.push_back(ea[31-8*i -: 8]);
    exp_b.push_back((c == 6'd8) ? 8'h87 : 8'h95);
    for (int i = 0; i < (tmo ? LIMIT : nbusy + 1); i++) exp_b.push_back(8'hFF);
    if (has_x && !tmo) for (int i = 0; i < 4; i++) exp_b.push_back(8'hFF);
    for (int i = 0; i < exp_b.size(); i++) exp_c.push_back(1'b0);
    if (!keep || tmo) begin exp_b.push_back(8'hFF); exp_c.push_back(1'b1); end

    done_cnt = 0;
    @(negedge clk);
    start = 1'b1; cmd_idx = c; cmd_arg = a; keep_sel = keep;
    @(negedge clk);
    start = 1'b0; cmd_idx = 6'd0; cmd_arg = 32'h0; keep_sel = 1'b0;
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (hijack && cyc == 8) begin start = 1'b1; cmd_idx = 6'd24; cmd_arg = 32'hFFFF_0000; keep_sel = 1'b1; end
      if (hijack && cyc == 9) begin start = 1'b0; cmd_idx = 6'd0; cmd_arg = 32'h0; keep_sel = 1'b0; end
    end
    chk(!busy, {tag, " R10 busy low with done"}, busy, 0);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, {tag, " R10/R8 one done"}, done_cnt, 1);
    chk(tx_log.size() == exp_b.size(), {tag, " R3/R4/R5/R6 byte count"},
        tx_log.size(), exp_b.size());
    for (int i = 0; i < exp_b.size() && i < tx_log.size(); i++) begin
      if (i < 6 || tx_log[i] !== exp_b[i])
        chk(tx_log[i] === exp_b[i], $sformatf("%s R1/R2 byte %0d", tag, i), tx_log[i], exp_b[i]);
      if (cs_log[i] !== exp_c[i])
        chk(1'b0, $sformatf("%s R6 cs on byte %0d", tag, i), cs_log[i], exp_c[i]);
    end
    chk(timeout === tmo, {tag, " R4 timeout flag"}, timeout, tmo);
    chk(r1 === (tmo ? 8'hFF : rv), {tag, " R3 status"}, r1, tmo ? 8'hFF : rv);
    chk(ext === ((has_x && !tmo) ? xv : 32'h0), {tag, " R5 ext"}, ext,
        (has_x && !tmo) ? xv : 32'h0);
    chk(cs_n === ((keep && !tmo) ? 1'b0 : 1'b1), {tag, " R7 cs after done"}, cs_n,
        (keep && !tmo) ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(cs_n === 1'b1 && busy === 1'b0 && done === 1'b0 && xfer_req === 1'b0 &&
        timeout === 1'b0, "R9 reset controls", {cs_n, busy, done, xfer_req, timeout}, 5'b10000);
    chk(r1 === 8'h00 && ext === 32'h0, "R9 reset results", {r1, ext[23:0]}, 0);

    run(6'd17, 32'h1234_5678, 1'b0, 3, 8'h00, 32'h0, 1'b0, "read R1");
    run(6'd8,  32'hDEAD_BEEF, 1'b0, 1, 8'h01, 32'h0000_01AA, 1'b0, "ifcond R2");
    run(6'd58, 32'h0000_0000, 1'b0, 0, 8'h00, 32'hC0FF_8000, 1'b0, "ocr R5");
    run(6'd17, 32'h0000_0200, 1'b1, 2, 8'h00, 32'h0, 1'b0, "keep R7");
    run(6'd58, 32'hA5A5_0001, 1'b1, 1, 8'h01, 32'h8123_4567, 1'b0, "keepocr R7");
    run(6'd55, 32'h0000_0000, 1'b0, 4, 8'h7E, 32'h0, 1'b0, "flags R3");
    run(6'd0,  32'h0000_0000, 1'b0, 2, 8'h01, 32'h0, 1'b1, "hijack R8");
    run(6'd41, 32'h4000_0000, 1'b0, -1, 8'h00, 32'h0, 1'b0, "timeout R4");
    run(6'd1,  32'h0000_0000, 1'b1, -1, 8'h00, 32'h0, 1'b0, "keeptmo R7");
    run(6'd16, 32'h0000_0200, 1'b0, 0, 8'h04, 32'h0, 1'b0, "after R6");

    summary();
    $finish;
  end
endmodule